// File: doc/BRIEF.md
# Packed 16-bit accumulate unit

This unit executes one group of SIMD instructions against a private file of sixteen 32-bit extension registers. Each instruction names two source registers and two destination registers. A 2-bit pattern field gives each destination its own add-or-subtract choice. There are three operations. The pair operation forms lane-wise sums or differences of two sources and accumulates them into both destinations. The lane operation adds a source into a destination lane by lane, or subtracts it. The sum operation adds the two sign-extended halves of a source and accumulates that total into a full 32-bit destination.

The unit executes an instruction in the cycle its valid strobe is high. The register writes it performs appear on two write-report ports in that same cycle and commit at the clock edge. A reserved minor code raises a flag one cycle later. A debug port reads any register asynchronously and can write one. The debug write exists only to seed values, because the arithmetic cannot create a nonzero value from an all-zero file.

Top module: `pk16_acc_unit`

## Requirements
- R1: An instruction belongs to the group only when bits 5..0 equal 0x1B. A valid word with any other value there writes nothing and leaves the flag low.
- R2: Field positions are as follows. Minor op is in bits 23..22. Pattern is in bits 25..24. The first destination index (A) is in bits 9..6, the first source (B) in bits 13..10, the second source (C) in bits 17..14 and the second destination (D) in bits 21..18.
- R3: Minor 00 (pair) works per 16-bit lane: A += B ± C and D += B ± C. Pattern bit 1 selects subtraction for A and pattern bit 0 selects it for D. Every lane wraps modulo 2^16 with no carry into the neighbouring lane.
- R4: Minor 01 (lane) works per 16-bit lane: A = A ± B under pattern bit 1 and D = D ± C under pattern bit 0. Lanes wrap independently.
- R5: Minor 10 (sum) sign-extends both halves of B, adds them, and adds the result to all 32 bits of A or subtracts it (subtraction when pattern bit 1 is set). C and D are handled the same way under pattern bit 0. The result wraps modulo 2^32, and carries cross the lane boundary.
- R6: Minor 11 writes nothing and raises rsvd_flag for the single cycle after the instruction.
- R7: A destination index of 0 suppresses that write, and the other destination is still written.
- R8: All registers read zero after reset. Register 0 always reads zero, and a debug write to it has no effect.
- R9: All sources are read before any write. When A and D name the same nonzero register, the D update is applied on top of the A result, and the combined value is what gets stored.
- R10: wr_a_* and wr_d_* report each write in the cycle the instruction is valid. The new value can be read on dbg_data from the next cycle.
- R11: While insn_valid is low, nothing is written and rsvd_flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word |
| wr_a_en | output | 1 | First destination written this cycle |
| wr_a_idx | output | 4 | Register index of the first destination |
| wr_a_data | output | 32 | Value written to the first destination |
| wr_d_en | output | 1 | Second destination written this cycle |
| wr_d_idx | output | 4 | Register index of the second destination |
| wr_d_data | output | 32 | Value written to the second destination (final value when the two destinations alias) |
| rsvd_flag | output | 1 | Reserved minor code seen in the previous cycle |
| dbg_addr | input | 4 | Debug register index |
| dbg_we | input | 1 | Debug write enable (used for seeding) |
| dbg_wdata | input | 32 | Debug write data |
| dbg_data | output | 32 | Combinational read of register dbg_addr |

## Verification
The write-report ports are combinational from the instruction, so the bench samples them 2 ns after driving the word on a falling edge, in the same cycle. The register contents and rsvd_flag change at the following rising edge, so the bench reads dbg_data and the flag only after the next falling edge, one cycle after issue. Seeding through the debug port also commits at a rising edge, and the bench finishes each seed before it issues the instruction that uses it.

// File: rtl/pk16_pkg.sv
// Package for the packed accumulate unit. Holds the shared widths, the
// operation codes and the decoded-instruction record.
package pk16_pkg;

    localparam int XR_DATA_W = 32;   // extension register width
    localparam int XR_LANE_W = 16;   // packed lane width
    localparam int XR_IDX_W  = 4;    // register index width
    localparam int XR_OPC_W  = 6;    // major opcode width

    // Minor operation codes. The values are fixed by the instruction encoding.
    typedef enum logic [1:0] {
        PK_OP_PAIR = 2'b00,
        PK_OP_LANE = 2'b01,
        PK_OP_SUM  = 2'b10,
        PK_OP_RSVD = 2'b11
    } pk_op_e;

    typedef struct packed {
        logic                exec;   // valid group member with a real op
        logic                rsvd;   // valid group member with the reserved op
        pk_op_e              op;
        logic                sub_a;  // subtract for destination A
        logic                sub_d;  // subtract for destination D
        logic [XR_IDX_W-1:0] idx_a;
        logic [XR_IDX_W-1:0] idx_b;
        logic [XR_IDX_W-1:0] idx_c;
        logic [XR_IDX_W-1:0] idx_d;
    } pk_dec_t;

endpackage

// File: rtl/pk16_decode.sv
// Instruction decoder. Matches the major opcode, then splits out the minor
// op, the pattern bits and the four register indices.
// Assumes a 32-bit word with the major opcode in the low bits.
module pk16_decode
    import pk16_pkg::*;
#(
    parameter logic [XR_OPC_W-1:0] MAJOR_OP = 6'h1B
) (
    input  logic                 valid_i,
    input  logic [XR_DATA_W-1:0] word_i,
    output pk_dec_t              dec_o
);

    localparam int MINOR_LSB = 22;
    localparam int PAT_LSB   = 24;
    localparam int A_LSB     = 6;
    localparam int B_LSB     = A_LSB + XR_IDX_W;
    localparam int C_LSB     = B_LSB + XR_IDX_W;
    localparam int D_LSB     = C_LSB + XR_IDX_W;
    localparam int TOP_LSB   = PAT_LSB + 2;

    logic   hit;
    pk_op_e op;
    logic   unused_hi;

    assign unused_hi = ^word_i[XR_DATA_W-1:TOP_LSB];

    // Split the fields and classify the word.
    always_comb begin
        hit         = valid_i && (word_i[XR_OPC_W-1:0] == MAJOR_OP);
        op          = pk_op_e'(word_i[MINOR_LSB +: 2]);
        dec_o.op    = op;
        dec_o.rsvd  = hit && (op == PK_OP_RSVD);
        dec_o.exec  = hit && (op != PK_OP_RSVD);
        dec_o.sub_a = word_i[PAT_LSB + 1];
        dec_o.sub_d = word_i[PAT_LSB];
        dec_o.idx_a = word_i[A_LSB +: XR_IDX_W];
        dec_o.idx_b = word_i[B_LSB +: XR_IDX_W];
        dec_o.idx_c = word_i[C_LSB +: XR_IDX_W];
        dec_o.idx_d = word_i[D_LSB +: XR_IDX_W];
    end

endmodule

// File: rtl/pk16_dest_alu.sv
// Computes the new value of one destination from its current value (base)
// and two source words.
//   pair: every lane gets base + (x +/- y)
//   lane: every lane gets base +/- x
//   sum : all 32 bits get base +/- (sum of the sign-extended lanes of x)
// Lane results wrap within the lane. The sum result wraps at the full width.
module pk16_dest_alu
    import pk16_pkg::*;
#(
    parameter int DATA_W = XR_DATA_W,
    parameter int LANE_W = XR_LANE_W
) (
    input  pk_op_e            op_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] pair_res;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] lane_sum;
    logic [DATA_W-1:0] sum_res;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] b_l;
        logic [LANE_W-1:0] x_l;
        logic [LANE_W-1:0] y_l;
        logic [LANE_W-1:0] inner;
        assign b_l   = base_i[g*LANE_W +: LANE_W];
        assign x_l   = x_i[g*LANE_W +: LANE_W];
        assign y_l   = y_i[g*LANE_W +: LANE_W];
        assign inner = sub_i ? (x_l - y_l) : (x_l + y_l);
        assign pair_res[g*LANE_W +: LANE_W] = b_l + inner;
        assign lane_res[g*LANE_W +: LANE_W] = sub_i ? (b_l - x_l) : (b_l + x_l);
    end

    // Add the sign-extended lanes of x at full width.
    always_comb begin
        lane_sum = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_sum = lane_sum + {{(DATA_W-LANE_W){x_i[k*LANE_W + LANE_W - 1]}},
                                   x_i[k*LANE_W +: LANE_W]};
        end
    end

    assign sum_res = sub_i ? (base_i - lane_sum) : (base_i + lane_sum);

    // Pick the result of the decoded operation.
    always_comb begin
        unique case (op_i)
            PK_OP_PAIR: res_o = pair_res;
            PK_OP_LANE: res_o = lane_res;
            PK_OP_SUM:  res_o = sum_res;
            default:    res_o = base_i;
        endcase
    end

endmodule

// File: rtl/pk16_regfile.sv
// Extension register file with RD_PORTS asynchronous read ports and three
// write ports: debug, destination A and destination D.
// When two ports write the same entry in one cycle, D wins over A and A
// wins over debug. Entry 0 is hard-wired to zero.
module pk16_regfile
    import pk16_pkg::*;
#(
    parameter int DATA_W   = XR_DATA_W,
    parameter int IDX_W    = XR_IDX_W,
    parameter int RD_PORTS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i  [RD_PORTS],
    output logic [DATA_W-1:0] rd_data_o [RD_PORTS],
    input  logic              dbg_we_i,
    input  logic [IDX_W-1:0]  dbg_idx_i,
    input  logic [DATA_W-1:0] dbg_data_i,
    input  logic              wa_en_i,
    input  logic [IDX_W-1:0]  wa_idx_i,
    input  logic [DATA_W-1:0] wa_data_i,
    input  logic              wd_en_i,
    input  logic [IDX_W-1:0]  wd_idx_i,
    input  logic [DATA_W-1:0] wd_data_i
);

    localparam int NREGS = 1 << IDX_W;

    logic [DATA_W-1:0] regs [NREGS];

    assign regs[0] = '0;

    for (genvar i = 1; i < NREGS; i++) begin : g_reg
        // Hold entry i and apply the highest-priority write that targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wd_en_i && (wd_idx_i == IDX_W'(i))) begin
                regs[i] <= wd_data_i;
            end else if (wa_en_i && (wa_idx_i == IDX_W'(i))) begin
                regs[i] <= wa_data_i;
            end else if (dbg_we_i && (dbg_idx_i == IDX_W'(i))) begin
                regs[i] <= dbg_data_i;
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_data_o[p] = regs[rd_idx_i[p]];
    end

endmodule

// File: rtl/pk16_acc_unit.sv
// Packed 16-bit accumulate execution unit (top). Decodes one instruction
// group, reads both sources and both destinations from the register file,
// computes the two destination values and writes them in the same cycle.
// Assumes one instruction per cycle and no outside hazard handling.
// Write-report ports are combinational. rsvd_flag is registered.
module pk16_acc_unit
    import pk16_pkg::*;
#(
    parameter logic [XR_OPC_W-1:0] MAJOR_OP = 6'h1B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 insn_valid,
    input  logic [XR_DATA_W-1:0] insn_word,
    output logic                 wr_a_en,
    output logic [XR_IDX_W-1:0]  wr_a_idx,
    output logic [XR_DATA_W-1:0] wr_a_data,
    output logic                 wr_d_en,
    output logic [XR_IDX_W-1:0]  wr_d_idx,
    output logic [XR_DATA_W-1:0] wr_d_data,
    output logic                 rsvd_flag,
    input  logic [XR_IDX_W-1:0]  dbg_addr,
    input  logic                 dbg_we,
    input  logic [XR_DATA_W-1:0] dbg_wdata,
    output logic [XR_DATA_W-1:0] dbg_data
);

    localparam int RD_PORTS = 5;
    localparam int P_A = 0;
    localparam int P_B = 1;
    localparam int P_C = 2;
    localparam int P_D = 3;
    localparam int P_G = 4;

    pk_dec_t              dec;
    logic [XR_IDX_W-1:0]  rd_idx  [RD_PORTS];
    logic [XR_DATA_W-1:0] rd_data [RD_PORTS];
    logic [XR_DATA_W-1:0] res_a;
    logic [XR_DATA_W-1:0] res_d;
    logic [XR_DATA_W-1:0] base_d;
    logic [XR_DATA_W-1:0] x_d;
    logic                 alias_ad;

    pk16_decode #(
        .MAJOR_OP (MAJOR_OP)
    ) u_decode (
        .valid_i (insn_valid),
        .word_i  (insn_word),
        .dec_o   (dec)
    );

    assign rd_idx[P_A] = dec.idx_a;
    assign rd_idx[P_B] = dec.idx_b;
    assign rd_idx[P_C] = dec.idx_c;
    assign rd_idx[P_D] = dec.idx_d;
    assign rd_idx[P_G] = dbg_addr;

    pk16_regfile #(
        .DATA_W   (XR_DATA_W),
        .IDX_W    (XR_IDX_W),
        .RD_PORTS (RD_PORTS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (rd_data),
        .dbg_we_i   (dbg_we),
        .dbg_idx_i  (dbg_addr),
        .dbg_data_i (dbg_wdata),
        .wa_en_i    (wr_a_en),
        .wa_idx_i   (wr_a_idx),
        .wa_data_i  (wr_a_data),
        .wd_en_i    (wr_d_en),
        .wd_idx_i   (wr_d_idx),
        .wd_data_i  (wr_d_data)
    );

    assign wr_a_en  = dec.exec && (dec.idx_a != '0);
    assign wr_d_en  = dec.exec && (dec.idx_d != '0);
    assign wr_a_idx = dec.idx_a;
    assign wr_d_idx = dec.idx_d;

    // Pair op: both destinations take B and C. Other ops: D takes C.
    assign x_d      = (dec.op == PK_OP_PAIR) ? rd_data[P_B] : rd_data[P_C];
    // Aliased destinations: D accumulates on top of the A result.
    assign alias_ad = wr_a_en && (dec.idx_a == dec.idx_d);
    assign base_d   = alias_ad ? res_a : rd_data[P_D];

    pk16_dest_alu #(
        .DATA_W (XR_DATA_W),
        .LANE_W (XR_LANE_W)
    ) u_alu_a (
        .op_i   (dec.op),
        .sub_i  (dec.sub_a),
        .base_i (rd_data[P_A]),
        .x_i    (rd_data[P_B]),
        .y_i    (rd_data[P_C]),
        .res_o  (res_a)
    );

    pk16_dest_alu #(
        .DATA_W (XR_DATA_W),
        .LANE_W (XR_LANE_W)
    ) u_alu_d (
        .op_i   (dec.op),
        .sub_i  (dec.sub_d),
        .base_i (base_d),
        .x_i    (x_d),
        .y_i    (rd_data[P_C]),
        .res_o  (res_d)
    );

    assign wr_a_data = res_a;
    assign wr_d_data = res_d;
    assign dbg_data  = rd_data[P_G];

    // Flag a reserved minor code for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsvd_flag <= 1'b0;
        end else begin
            rsvd_flag <= dec.rsvd;
        end
    end

endmodule

// File: rtl/pk16_acc_checker.sv
// Protocol checker for pk16_acc_unit, attached through bind. It sees the
// top-level ports only.
module pk16_acc_checker
    import pk16_pkg::*;
#(
    parameter logic [XR_OPC_W-1:0] MAJOR_OP = 6'h1B
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 insn_valid,
    input logic [XR_DATA_W-1:0] insn_word,
    input logic                 wr_a_en,
    input logic [XR_IDX_W-1:0]  wr_a_idx,
    input logic                 wr_d_en,
    input logic [XR_IDX_W-1:0]  wr_d_idx,
    input logic                 rsvd_flag,
    input logic [XR_IDX_W-1:0]  dbg_addr,
    input logic [XR_DATA_W-1:0] dbg_data
);

    logic grp;
    logic rsv;
    logic run;

    assign grp = insn_valid && (insn_word[5:0] == MAJOR_OP);
    assign rsv = grp && (insn_word[23:22] == 2'b11);
    assign run = grp && (insn_word[23:22] != 2'b11);

    AST_FOREIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !grp) |-> (!wr_a_en && !wr_d_en));  // R1
    AST_FOREIGN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !grp) |=> !rsvd_flag);  // R1
    AST_A_IDX_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a_en |-> (wr_a_idx == insn_word[9:6]));  // R2
    AST_D_IDX_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d_en |-> (wr_d_idx == insn_word[21:18]));  // R2
    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |-> (!wr_a_en && !wr_d_en));  // R6
    AST_RSVD_FLAG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |=> rsvd_flag);  // R6
    AST_ZERO_A_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && insn_word[9:6] == '0) |-> !wr_a_en);  // R7
    AST_ZERO_D_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && insn_word[21:18] == '0) |-> !wr_d_en);  // R7
    AST_LIVE_A_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && insn_word[9:6] != '0) |-> wr_a_en);  // R7
    AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_data == '0));  // R8
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |-> (!wr_a_en && !wr_d_en));  // R11
    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !rsvd_flag);  // R11

endmodule

bind pk16_acc_unit pk16_acc_checker #(.MAJOR_OP(MAJOR_OP)) u_pk16_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .wr_a_en    (wr_a_en),
    .wr_a_idx   (wr_a_idx),
    .wr_d_en    (wr_d_en),
    .wr_d_idx   (wr_d_idx),
    .rsvd_flag  (rsvd_flag),
    .dbg_addr   (dbg_addr),
    .dbg_data   (dbg_data)
);

// File: tb/test_pk16_acc_unit.sv
`timescale 1ns/1ps
// Self-checking bench for pk16_acc_unit. A vector table drives the three
// operations, then directed tests cover reset, register 0, zero destinations,
// the reserved op, foreign opcodes, idle cycles and aliasing.
module test_pk16_acc_unit;

    typedef struct packed {
        logic [1:0]  pat;
        logic [1:0]  minor;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [3:0]  rc;
        logic [3:0]  rd;
        logic [31:0] a0;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] d0;
        logic [31:0] ea;
        logic [31:0] ed;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'b00, 4'd1,  4'd2,  4'd3,  4'd4,  32'h0001_0002, 32'h0010_0020, 32'h0003_0004, 32'h1000_2000, 32'h0014_0026, 32'h1013_2024},
        '{2'b10, 2'b00, 4'd5,  4'd6,  4'd7,  4'd8,  32'h0000_0000, 32'h0005_0001, 32'h0002_0003, 32'hFFFF_FFFF, 32'h0003_FFFE, 32'h0006_0003},
        '{2'b01, 2'b00, 4'd9,  4'd10, 4'd11, 4'd12, 32'h1111_1111, 32'h8000_7FFF, 32'h8000_0001, 32'h0000_0000, 32'h1111_9111, 32'h0000_7FFE},
        '{2'b00, 2'b01, 4'd13, 4'd14, 4'd15, 4'd1,  32'h1234_FFFF, 32'h0001_0001, 32'h0002_0002, 32'h0000_0001, 32'h1235_0000, 32'h0002_0003},
        '{2'b11, 2'b01, 4'd2,  4'd3,  4'd4,  4'd5,  32'h0000_0000, 32'h0001_0001, 32'h0001_0060, 32'h0100_0050, 32'hFFFF_FFFF, 32'h00FF_FFF0},
        '{2'b10, 2'b01, 4'd6,  4'd7,  4'd8,  4'd9,  32'h0010_0010, 32'h0020_0001, 32'h0001_0001, 32'h7FFF_7FFF, 32'hFFF0_000F, 32'h8000_8000},
        '{2'b00, 2'b10, 4'd10, 4'd11, 4'd12, 4'd13, 32'h0000_0005, 32'hFFFF_0001, 32'h7FFF_7FFF, 32'h0000_0002, 32'h0000_0005, 32'h0001_0000},
        '{2'b11, 2'b10, 4'd14, 4'd15, 4'd1,  4'd2,  32'h0000_0000, 32'h8000_8000, 32'h0001_0002, 32'h0000_0001, 32'h0001_0000, 32'hFFFF_FFFE},
        '{2'b01, 2'b10, 4'd3,  4'd4,  4'd5,  4'd6,  32'hFFFF_FFFF, 32'h0003_FFFE, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_0000, 32'h0000_0012},
        '{2'b10, 2'b10, 4'd7,  4'd8,  4'd9,  4'd10, 32'h0000_0004, 32'h0002_0003, 32'h8000_0000, 32'h0000_8000, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        wr_a_en, wr_d_en, rsvd_flag;
    logic [3:0]  wr_a_idx, wr_d_idx;
    logic [31:0] wr_a_data, wr_d_data, dbg_data;
    logic [3:0]  dbg_addr = '0;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic        s_wa_en, s_wd_en, s_flag;
    logic [3:0]  s_wa_idx, s_wd_idx;
    logic [31:0] s_wa_data, s_wd_data;
    logic [31:0] rv;

    always #10 clk = ~clk;

    pk16_acc_unit i_pk16_acc_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .wr_a_en    (wr_a_en),
        .wr_a_idx   (wr_a_idx),
        .wr_a_data  (wr_a_data),
        .wr_d_en    (wr_d_en),
        .wr_d_idx   (wr_d_idx),
        .wr_d_data  (wr_d_data),
        .rsvd_flag  (rsvd_flag),
        .dbg_addr   (dbg_addr),
        .dbg_we     (dbg_we),
        .dbg_wdata  (dbg_wdata),
        .dbg_data   (dbg_data)
    );

    function automatic logic [31:0] mk(input logic [1:0] pat, input logic [1:0] minor,
                                       input logic [3:0] d, input logic [3:0] c,
                                       input logic [3:0] b, input logic [3:0] a,
                                       input logic [5:0] major);
        return {6'b0, pat, minor, d, c, b, a, major};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic seed(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = idx; dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        @(negedge clk);
        dbg_addr = idx;
        #2 val = dbg_data;
    endtask

    // Drive one word for one cycle. Capture the write ports in that cycle
    // and the flag in the cycle after.
    task automatic issue(input logic v, input logic [31:0] w);
        @(negedge clk);
        insn_valid = v; insn_word = w;
        #2;
        s_wa_en = wr_a_en; s_wa_idx = wr_a_idx; s_wa_data = wr_a_data;
        s_wd_en = wr_d_en; s_wd_idx = wr_d_idx; s_wd_data = wr_d_data;
        @(negedge clk);
        insn_valid = 1'b0; insn_word = '0;
        #2 s_flag = rsvd_flag;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        string req;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state of every register and of the flag.
        #2 chk("R8 flag after reset", {31'b0, rsvd_flag}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), rv);
            chk("R8 reset value", rv, 32'h0);
        end

        // Table walk: R3 pair, R4 lane, R5 sum, with R10 port timing.
        for (int v = 0; v < NVEC; v++) begin
            req = (VECS[v].minor == 2'b00) ? "R3" : (VECS[v].minor == 2'b01) ? "R4" : "R5";
            seed(VECS[v].rb, VECS[v].b);
            seed(VECS[v].rc, VECS[v].c);
            seed(VECS[v].ra, VECS[v].a0);
            seed(VECS[v].rd, VECS[v].d0);
            issue(1'b1, mk(VECS[v].pat, VECS[v].minor, VECS[v].rd, VECS[v].rc,
                           VECS[v].rb, VECS[v].ra, 6'h1B));
            chk({req, " R10 A port data"}, s_wa_data, VECS[v].ea);
            chk({req, " R10 D port data"}, s_wd_data, VECS[v].ed);
            chk("R2 A port idx", {28'b0, s_wa_idx}, {28'b0, VECS[v].ra});
            chk("R2 D port idx", {28'b0, s_wd_idx}, {28'b0, VECS[v].rd});
            rd(VECS[v].ra, rv);
            chk({req, " A stored"}, rv, VECS[v].ea);
            rd(VECS[v].rd, rv);
            chk({req, " D stored"}, rv, VECS[v].ed);
        end

        // R8: a debug write to register 0 has no effect.
        seed(4'd0, 32'hDEAD_BEEF);
        rd(4'd0, rv);
        chk("R8 reg0 write ignored", rv, 32'h0);

        // R7: A index 0 is skipped, D is still written (pair, add).
        seed(4'd2, 32'h0000_0001);
        seed(4'd3, 32'h0000_0002);
        seed(4'd4, 32'h0000_0010);
        issue(1'b1, mk(2'b00, 2'b00, 4'd4, 4'd3, 4'd2, 4'd0, 6'h1B));
        chk("R7 A skipped", {31'b0, s_wa_en}, 32'h0);
        chk("R7 D enabled", {31'b0, s_wd_en}, 32'h1);
        rd(4'd4, rv);
        chk("R7 D stored", rv, 32'h0000_0013);
        rd(4'd0, rv);
        chk("R7 reg0 untouched", rv, 32'h0);

        // R6: reserved minor code, no write, flag one cycle later.
        seed(4'd1, 32'hAAAA_5555);
        issue(1'b1, mk(2'b00, 2'b11, 4'd4, 4'd3, 4'd2, 4'd1, 6'h1B));
        chk("R6 no A write", {31'b0, s_wa_en}, 32'h0);
        chk("R6 no D write", {31'b0, s_wd_en}, 32'h0);
        chk("R6 flag raised", {31'b0, s_flag}, 32'h1);
        rd(4'd1, rv);
        chk("R6 A unchanged", rv, 32'hAAAA_5555);
        #2 chk("R6 flag one cycle", {31'b0, rsvd_flag}, 32'h0);

        // R1: another major opcode is ignored.
        issue(1'b1, mk(2'b00, 2'b00, 4'd4, 4'd3, 4'd2, 4'd1, 6'h1A));
        chk("R1 no A write", {31'b0, s_wa_en}, 32'h0);
        chk("R1 no flag", {31'b0, s_flag}, 32'h0);
        rd(4'd1, rv);
        chk("R1 A unchanged", rv, 32'hAAAA_5555);

        // R11: a group word with valid low is ignored.
        issue(1'b0, mk(2'b00, 2'b00, 4'd4, 4'd3, 4'd2, 4'd1, 6'h1B));
        chk("R11 no D write", {31'b0, s_wd_en}, 32'h0);
        rd(4'd1, rv);
        chk("R11 A unchanged", rv, 32'hAAAA_5555);
        issue(1'b0, mk(2'b00, 2'b11, 4'd4, 4'd3, 4'd2, 4'd1, 6'h1B));
        chk("R11 no flag", {31'b0, s_flag}, 32'h0);

        // R9: A and D alias, D accumulates on top of A (lane op, add).
        seed(4'd5, 32'h0100_0100);
        seed(4'd6, 32'h0001_0001);
        seed(4'd7, 32'h0010_0010);
        issue(1'b1, mk(2'b00, 2'b01, 4'd5, 4'd7, 4'd6, 4'd5, 6'h1B));
        chk("R9 alias D port", s_wd_data, 32'h0111_0111);
        rd(4'd5, rv);
        chk("R9 alias stored", rv, 32'h0111_0111);

        // R9: the source equals the destination and is read before the write.
        issue(1'b1, mk(2'b00, 2'b01, 4'd0, 4'd7, 4'd5, 4'd5, 6'h1B));
        chk("R9 self source", s_wa_data, 32'h0222_0222);
        chk("R7 D zero skipped", {31'b0, s_wd_en}, 32'h0);
        rd(4'd5, rv);
        chk("R9 self stored", rv, 32'h0222_0222);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule